// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Logic

This block holds the status register of a serial NOR flash and decides, for every decoded command, whether it may run. The command strobes arrive already decoded: write enable, write disable, status write, page program, sector erase, block erase and chip erase. Each strobe comes with a target address, status write data, the active-low write-protect pin and a mode select that switches the status view to the one-time-programmable (OTP) layout. Every command that is not ignored gets exactly one verdict, accept or reject, as a one-cycle pulse. An accepted status write, program or erase starts a busy period whose length is a parameter for each operation.

The protection state is kept in ordinary registers that stand in for non-volatile cells. There is a normal set: status-protect, pin-disable and a four-bit protect level. There is also a separate OTP set: an OTP lock, a boot-lock side select, a boot-lock granularity select and a boot-lock enable. The array is sixteen 64 KB blocks of sixteen sectors each. The address is the sector index, and its upper four bits give the block.

Top module: `flash_sr_guard`

## Requirements
- R1: After synchronous reset every protection bit, the write-enable latch and the busy flag are 0, so both status views read 0x00, and neither verdict pulse is high.
- R2: Write enable sets the write-enable latch (status bit 1) and write disable clears it. Both are accepted whenever the block is idle.
- R3: Each command issued while idle gives exactly one verdict pulse, accept or reject, in the cycle after the strobe. Status write, program and any erase are rejected while the latch is 0. Every rejection clears the latch.
- R4: An accepted status write, program, sector erase, block erase or chip erase raises busy (status bit 0) in the cycle after the strobe. Busy stays high for exactly 3, 5, 7, 9 or 11 cycles respectively (default parameters). The latch clears in the same cycle that busy falls.
- R5: While busy is 1, every command strobe is ignored: there is no verdict pulse and no change to the latch or the protection bits.
- R6: The normal view is {status-protect[7], pin-disable[6], protect level[5:2], latch[1], busy[0]}. Status write loads bits 7:2 and never bits 1:0. A protect level n of 1..4 protects the top 2^(n-1) blocks, and n of 5 or more protects all 16.
- R7: Program, sector erase and block erase whose target block lies in the protected top region are rejected in normal mode.
- R8: Chip erase in normal mode is accepted only when the protect level is 0 and the boot lock is not enabled.
- R9: When status-protect is 1, pin-disable is 0 and the write-protect pin is low, status write is rejected and the normal bits keep their value.
- R10: When pin-disable is 1, the write-protect pin has no effect, and status write is accepted with status-protect set and the pin low.
- R11: With the OTP select high, the view is {OTP lock[7], side[6], 0[5], granularity[4], boot-lock enable[3], 0[2], latch[1], busy[0]}. A status write in this mode touches only the OTP set, and bits 5, 2, 1 and 0 of its data have no effect.
- R12: Once boot-lock enable is 1 it stays 1, and later status writes do not change side or granularity. The locked region is block 15 or block 0 (side 0 or 1) when granularity is 0, or sector 0xFF or sector 0x00 when granularity is 1. Program and sector erase into it are rejected, and so is block erase of the block that holds it.
- R13: The OTP lock can only be set, never cleared. With the OTP select high, program and erase commands are accepted only while the OTP lock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_sect_erase | input | 1 | Sector-erase strobe |
| cmd_blk_erase | input | 1 | Block-erase strobe |
| cmd_chip_erase | input | 1 | Chip-erase strobe |
| addr | input | 8 | Target sector index (bits 7:4 are the block) |
| wr_data | input | 8 | Status-write data |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | Selects the OTP view and the OTP target |
| status_out | output | 8 | Status view for the current mode |
| cmd_accepted | output | 1 | One-cycle pulse for an accepted command |
| cmd_rejected | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hardest state to reach is the boot lock. Several status writes in OTP mode must set the side and granularity first, then set the enable, then try to change the frozen fields. Only after that can a normal-mode program show the rejection at the single locked sector while its neighbour in the same block is still accepted. The stimulus table walks this order with a write enable before each step. It also covers protect-pin overrides and OTP lock stickiness. Directed tests then count busy cycles and issue a write disable in the middle of an erase.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [2:0] {
        OP_NONE, OP_WREN, OP_WRDI, OP_WRSR,
        OP_PROG, OP_SERASE, OP_BERASE, OP_CERASE
    } op_e;

    // Normal-mode non-volatile set, ordered as it appears in bits 7:2
    typedef struct packed {
        logic       srp;
        logic       wpdis;
        logic [3:0] level;
    } nv_bits_t;

    // OTP-mode set
    typedef struct packed {
        logic lock;
        logic side;
        logic gran;
        logic ebl;
    } otp_bits_t;

    typedef struct packed {
        logic accept;
        logic reject;
        logic wel_set;
        logic wel_clr;
        logic load_nv;
        logic load_otp;
        logic start;
    } verdict_t;

    function automatic op_e pick_op(input logic wren, input logic wrdi,
                                    input logic wrsr, input logic prog,
                                    input logic serase, input logic berase,
                                    input logic cerase);
        if (wrsr)        return OP_WRSR;
        else if (prog)   return OP_PROG;
        else if (serase) return OP_SERASE;
        else if (berase) return OP_BERASE;
        else if (cerase) return OP_CERASE;
        else if (wrdi)   return OP_WRDI;
        else if (wren)   return OP_WREN;
        return OP_NONE;
    endfunction

    function automatic logic [7:0] nv_view(input nv_bits_t nv, input logic wel,
                                           input logic wip);
        return {nv.srp, nv.wpdis, nv.level, wel, wip};
    endfunction

    function automatic logic [7:0] otp_view(input otp_bits_t o, input logic wel,
                                            input logic wip);
        return {o.lock, o.side, 1'b0, o.gran, o.ebl, 1'b0, wel, wip};
    endfunction

endpackage

// File: rtl/sr_region_check.sv
module sr_region_check #(
    parameter int NBLK_LOG2 = 4,
    parameter int SEC_LOG2  = 4
) (
    input  logic [NBLK_LOG2+SEC_LOG2-1:0] addr,
    input  logic [3:0]                    level,
    input  logic                          side,
    input  logic                          gran,
    input  logic                          ebl,
    output logic                          level_hit,
    output logic                          boot_blk_hit,
    output logic                          boot_sec_hit
);
    localparam int AW   = NBLK_LOG2 + SEC_LOG2;
    localparam int NBLK = 1 << NBLK_LOG2;

    logic [NBLK_LOG2-1:0] blk;
    logic [NBLK_LOG2-1:0] lock_blk;
    logic [AW-1:0]        lock_sec;
    logic [NBLK_LOG2:0]   span;
    logic [NBLK_LOG2:0]   first_blk;

    assign blk      = addr[AW-1:SEC_LOG2];
    assign lock_blk = side ? '0 : '1;
    assign lock_sec = side ? '0 : '1;

    always_comb begin
        span      = '0;
        first_blk = (NBLK_LOG2+1)'(NBLK);
        level_hit = 1'b0;
        if (level != 4'd0) begin
            if (int'(level) > NBLK_LOG2) begin
                level_hit = 1'b1;
            end else begin
                span      = (NBLK_LOG2+1)'(1) << (level - 4'd1);
                first_blk = (NBLK_LOG2+1)'(NBLK) - span;
                level_hit = ({1'b0, blk} >= first_blk);
            end
        end
    end

    assign boot_blk_hit = ebl && (blk == lock_blk);
    assign boot_sec_hit = ebl && (gran ? (addr == lock_sec) : (blk == lock_blk));

endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= load;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);                                   // R5
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && load != '0) |=> busy);                    // R4
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                    // R4

endmodule

// File: rtl/sr_cmd_judge.sv
module sr_cmd_judge
    import flash_sr_pkg::*;
(
    input  op_e      op,
    input  logic     wel,
    input  logic     busy,
    input  logic     hw_prot,
    input  logic     otp_mode,
    input  logic     otp_lock,
    input  logic     level_nz,
    input  logic     level_hit,
    input  logic     boot_blk_hit,
    input  logic     boot_sec_hit,
    input  logic     ebl,
    output verdict_t v
);
    logic ok;

    always_comb begin
        v  = '0;
        ok = 1'b0;
        if (!busy) begin
            unique case (op)
                OP_WREN: begin v.accept = 1'b1; v.wel_set = 1'b1; end
                OP_WRDI: begin v.accept = 1'b1; v.wel_clr = 1'b1; end
                OP_WRSR: ok = wel && !hw_prot;
                OP_PROG, OP_SERASE:
                    ok = wel && (otp_mode ? !otp_lock : !(level_hit || boot_sec_hit));
                OP_BERASE:
                    ok = wel && (otp_mode ? !otp_lock : !(level_hit || boot_blk_hit));
                OP_CERASE:
                    ok = wel && (otp_mode ? !otp_lock : !(level_nz || ebl));
                default: ok = 1'b0;
            endcase
            if (op != OP_NONE && op != OP_WREN && op != OP_WRDI) begin
                if (ok) begin
                    v.accept   = 1'b1;
                    v.start    = 1'b1;
                    v.load_nv  = (op == OP_WRSR) && !otp_mode;
                    v.load_otp = (op == OP_WRSR) && otp_mode;
                end else begin
                    v.reject  = 1'b1;
                    v.wel_clr = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int NBLK_LOG2 = 4,
    parameter int SEC_LOG2  = 4,
    parameter int T_WRSR    = 3,
    parameter int T_PROG    = 5,
    parameter int T_SERASE  = 7,
    parameter int T_BERASE  = 9,
    parameter int T_CERASE  = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_wrsr,
    input  logic       cmd_prog,
    input  logic       cmd_sect_erase,
    input  logic       cmd_blk_erase,
    input  logic       cmd_chip_erase,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    input  logic       otp_mode,
    output logic [7:0] status_out,
    output logic       cmd_accepted,
    output logic       cmd_rejected
);
    localparam int AW   = NBLK_LOG2 + SEC_LOG2;
    localparam int TM1  = (T_WRSR > T_PROG) ? T_WRSR : T_PROG;
    localparam int TM2  = (T_SERASE > T_BERASE) ? T_SERASE : T_BERASE;
    localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX = (TM3 > T_CERASE) ? TM3 : T_CERASE;
    localparam int CW   = $clog2(TMAX + 1);

    nv_bits_t      nv_q;
    otp_bits_t     otp_q;
    logic          wel_q;
    logic          acc_q, rej_q;
    op_e           op;
    verdict_t      v;
    logic          wip, done, hw_prot;
    logic          level_hit, boot_blk_hit, boot_sec_hit;
    logic [CW-1:0] load;

    assign op      = pick_op(cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog,
                             cmd_sect_erase, cmd_blk_erase, cmd_chip_erase);
    assign hw_prot = nv_q.srp && !nv_q.wpdis && !wp_n;

    always_comb begin
        unique case (op)
            OP_WRSR:   load = CW'(T_WRSR);
            OP_PROG:   load = CW'(T_PROG);
            OP_SERASE: load = CW'(T_SERASE);
            OP_BERASE: load = CW'(T_BERASE);
            OP_CERASE: load = CW'(T_CERASE);
            default:   load = '0;
        endcase
    end

    sr_region_check #(.NBLK_LOG2(NBLK_LOG2), .SEC_LOG2(SEC_LOG2)) u_region (
        .addr         (addr[AW-1:0]),
        .level        (nv_q.level),
        .side         (otp_q.side),
        .gran         (otp_q.gran),
        .ebl          (otp_q.ebl),
        .level_hit    (level_hit),
        .boot_blk_hit (boot_blk_hit),
        .boot_sec_hit (boot_sec_hit)
    );

    sr_cmd_judge u_judge (
        .op           (op),
        .wel          (wel_q),
        .busy         (wip),
        .hw_prot      (hw_prot),
        .otp_mode     (otp_mode),
        .otp_lock     (otp_q.lock),
        .level_nz     (nv_q.level != 4'd0),
        .level_hit    (level_hit),
        .boot_blk_hit (boot_blk_hit),
        .boot_sec_hit (boot_sec_hit),
        .ebl          (otp_q.ebl),
        .v            (v)
    );

    sr_busy_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (v.start),
        .load  (load),
        .busy  (wip),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q  <= '0;
            otp_q <= '0;
            wel_q <= 1'b0;
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            acc_q <= v.accept;
            rej_q <= v.reject;
            if (v.wel_set)              wel_q <= 1'b1;
            else if (v.wel_clr || done) wel_q <= 1'b0;
            if (v.load_nv) nv_q <= nv_bits_t'(wr_data[7:2]);
            if (v.load_otp) begin
                otp_q.lock <= otp_q.lock | wr_data[7];
                if (!otp_q.ebl) begin
                    otp_q.side <= wr_data[6];
                    otp_q.gran <= wr_data[4];
                    otp_q.ebl  <= wr_data[3];
                end
            end
        end
    end

    assign status_out   = otp_mode ? otp_view(otp_q, wel_q, wip)
                                   : nv_view(nv_q, wel_q, wip);
    assign cmd_accepted = acc_q;
    assign cmd_rejected = rej_q;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(acc_q && rej_q));                                              // R3
    AST_REJECT_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        rej_q |-> !wel_q);                                               // R3
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        v.start |-> wel_q);                                              // R3
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wip && op != OP_NONE) |=> (!acc_q && !rej_q));                  // R5
    AST_HWP_BLOCKS_WRSR: assert property (@(posedge clk) disable iff (rst)
        (hw_prot && op == OP_WRSR && !wip) |=> rej_q);                   // R9
    AST_CE_NEEDS_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CERASE && !otp_mode && nv_q.level != 4'd0) |=> !acc_q); // R8
    AST_EBL_STICKY: assert property (@(posedge clk) disable iff (rst)
        otp_q.ebl |=> otp_q.ebl);                                        // R12
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        otp_q.lock |=> otp_q.lock);                                      // R13

endmodule

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;
    localparam int NV = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
    logic cmd_sect_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
    logic [7:0] addr = '0, wr_data = '0;
    logic wp_n = 1'b1, otp_mode = 1'b0;
    logic [7:0] status_out;
    logic cmd_accepted, cmd_rejected;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    flash_sr_guard dut (
        .clk(clk), .rst(rst),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_blk_erase(cmd_blk_erase), .cmd_chip_erase(cmd_chip_erase),
        .addr(addr), .wr_data(wr_data), .wp_n(wp_n), .otp_mode(otp_mode),
        .status_out(status_out), .cmd_accepted(cmd_accepted),
        .cmd_rejected(cmd_rejected)
    );

    // codes: 1 wren 2 wrdi 3 wrsr 4 prog 5 sector erase 6 block erase 7 chip erase
    // vector: {req[3:0], code[2:0], addr[7:0], data[7:0], wp_n, otp, exp_acc, exp_status[7:0]}
    function automatic logic [33:0] mk(input int req, input int code, input int a,
                                       input int d, input int wp, input int otp,
                                       input int acc, input int st);
        return {4'(req), 3'(code), 8'(a), 8'(d), 1'(wp), 1'(otp), 1'(acc), 8'(st)};
    endfunction

    localparam logic [33:0] VEC [NV] = '{
        mk(3, 4, 8'h00, 0, 1, 0, 0, 8'h00),      // R3 program without latch
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),          // R2
        mk(6, 3, 0, 8'h04, 1, 0, 1, 8'h04),      // R6 level 1
        mk(2, 1, 0, 0, 1, 0, 1, 8'h06),
        mk(7, 5, 8'hF3, 0, 1, 0, 0, 8'h04),      // R7 block 15 protected
        mk(2, 1, 0, 0, 1, 0, 1, 8'h06),
        mk(7, 5, 8'hE0, 0, 1, 0, 1, 8'h04),      // R7 block 14 free
        mk(2, 1, 0, 0, 1, 0, 1, 8'h06),
        mk(8, 7, 0, 0, 1, 0, 0, 8'h04),          // R8 level nonzero
        mk(2, 1, 0, 0, 1, 0, 1, 8'h06),
        mk(6, 3, 0, 8'h88, 1, 0, 1, 8'h88),      // R6 srp + level 2
        mk(2, 1, 0, 0, 1, 0, 1, 8'h8A),
        mk(7, 6, 8'hE5, 0, 1, 0, 0, 8'h88),      // R7 block 14 now protected
        mk(2, 1, 0, 0, 1, 0, 1, 8'h8A),
        mk(9, 3, 0, 8'h00, 0, 0, 0, 8'h88),      // R9 hardware protect
        mk(2, 1, 0, 0, 1, 0, 1, 8'h8A),
        mk(9, 3, 0, 8'h40, 1, 0, 1, 8'h40),      // R9 pin high lets it through
        mk(2, 1, 0, 0, 1, 0, 1, 8'h42),
        mk(10, 3, 0, 8'hC0, 0, 0, 1, 8'hC0),
        mk(2, 1, 0, 0, 0, 0, 1, 8'hC2),
        mk(10, 3, 0, 8'hC4, 0, 0, 1, 8'hC4),     // R10 pin ignored
        mk(2, 1, 0, 0, 1, 0, 1, 8'hC6),
        mk(2, 2, 0, 0, 1, 0, 1, 8'hC4),          // R2 write disable
        mk(3, 7, 0, 0, 1, 0, 0, 8'hC4),          // R3 latch clear
        mk(2, 1, 0, 0, 1, 0, 1, 8'hC6),
        mk(6, 3, 0, 8'h03, 1, 0, 1, 8'h00),      // R6 bits 1:0 not loaded
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),
        mk(8, 7, 0, 0, 1, 0, 1, 8'h00),          // R8 level zero
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),
        mk(7, 4, 8'hFF, 0, 1, 0, 1, 8'h00),
        mk(11, 1, 0, 0, 1, 1, 1, 8'h02),
        mk(11, 3, 0, 8'h57, 1, 1, 1, 8'h50),     // R11 view and ignored bits
        mk(2, 1, 0, 0, 1, 1, 1, 8'h52),
        mk(12, 3, 0, 8'h18, 1, 1, 1, 8'h18),     // R12 enable boot lock
        mk(2, 1, 0, 0, 1, 1, 1, 8'h1A),
        mk(12, 3, 0, 8'h40, 1, 1, 1, 8'h18),     // R12 frozen fields
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),
        mk(12, 4, 8'hFF, 0, 1, 0, 0, 8'h00),     // R12 locked sector
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),
        mk(12, 4, 8'hFE, 0, 1, 0, 1, 8'h00),     // R12 neighbour sector
        mk(2, 1, 0, 0, 1, 0, 1, 8'h02),
        mk(8, 7, 0, 0, 1, 0, 0, 8'h00),          // R8 boot lock blocks chip erase
        mk(2, 1, 0, 0, 1, 1, 1, 8'h1A),
        mk(13, 4, 0, 0, 1, 1, 1, 8'h18),         // R13 OTP program allowed
        mk(2, 1, 0, 0, 1, 1, 1, 8'h1A),
        mk(13, 3, 0, 8'h80, 1, 1, 1, 8'h98),     // R13 set lock
        mk(2, 1, 0, 0, 1, 1, 1, 8'h9A),
        mk(13, 4, 0, 0, 1, 1, 0, 8'h98),         // R13 locked
        mk(2, 1, 0, 0, 1, 1, 1, 8'h9A),
        mk(13, 3, 0, 8'h00, 1, 1, 1, 8'h98)      // R13 sticky
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input int code);
        cmd_wren       = (code == 1);
        cmd_wrdi       = (code == 2);
        cmd_wrsr       = (code == 3);
        cmd_prog       = (code == 4);
        cmd_sect_erase = (code == 5);
        cmd_blk_erase  = (code == 6);
        cmd_chip_erase = (code == 7);
    endtask

    // drive at a falling edge, release and sample at the next one
    task automatic issue(input int code, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d;
        strobe(code);
        @(negedge clk);
        strobe(0);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && status_out[0]; k++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fails++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        int busy_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(status_out == 8'h00, "R1", status_out, 0);
        check(!cmd_accepted && !cmd_rejected, "R1", {cmd_accepted, cmd_rejected}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] vv;
            vv = VEC[i];
            wp_n = vv[10]; otp_mode = vv[9];
            issue(int'(vv[29:27]), vv[26:19], vv[18:11]);
            check(cmd_accepted == vv[8] && cmd_rejected == !vv[8],
                  $sformatf("R%0d verdict v%0d", vv[33:30], i),
                  {cmd_accepted, cmd_rejected}, {vv[8], !vv[8]});
            wait_idle();
            check(status_out == vv[7:0],
                  $sformatf("R%0d status v%0d", vv[33:30], i), status_out, vv[7:0]);
        end

        // R1 reset clears everything, including the sticky bits
        @(negedge clk); rst = 1'b1; wp_n = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        otp_mode = 1'b1; #1;
        check(status_out == 8'h00, "R1 otp view", status_out, 0);
        otp_mode = 1'b0; #1;
        check(status_out == 8'h00, "R1 normal view", status_out, 0);

        // R3 pulse lasts one cycle
        issue(1, 0, 0);
        check(cmd_accepted, "R3 pulse", cmd_accepted, 1);
        @(negedge clk);
        check(!cmd_accepted && !cmd_rejected, "R3 pulse width", {cmd_accepted, cmd_rejected}, 0);

        // R4 program busy length, latch clears when busy falls
        issue(4, 8'h10, 0);
        busy_cnt = 0;
        for (int k = 0; k < 50 && status_out[0]; k++) begin
            check(status_out[1], "R4 latch held while busy", status_out, 8'h03);
            busy_cnt++;
            @(negedge clk);
        end
        check(busy_cnt == 5, "R4 program busy cycles", busy_cnt, 5);
        check(status_out == 8'h00, "R4 latch cleared at end", status_out, 0);

        // R5 write disable during a sector erase is ignored
        issue(1, 0, 0);
        issue(5, 8'h20, 0);
        check(cmd_accepted, "R5 erase accepted", cmd_accepted, 1);
        issue(2, 0, 0);
        check(!cmd_accepted && !cmd_rejected, "R5 no verdict while busy",
              {cmd_accepted, cmd_rejected}, 0);
        check(status_out == 8'h03, "R5 latch untouched", status_out, 8'h03);
        busy_cnt = 2;
        for (int k = 0; k < 50 && status_out[0]; k++) begin
            busy_cnt++;
            @(negedge clk);
        end
        check(busy_cnt == 7, "R4 sector erase busy cycles", busy_cnt, 7);
        check(status_out == 8'h00, "R5 idle after erase", status_out, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule